// File: doc/BRIEF.md
# ADC Mux Configuration Command Decoder

This block turns the configuration bytes of one serial write transaction into the channel selection and operating mode of a multi-channel converter. An I2C target front end delivers each received data byte with a one-cycle valid strobe. It also flags the start of a transaction (including a repeated start) and its stop. The first byte of a transaction may carry a new input selection: a three-bit prefix decides whether the selection is loaded, kept, or refused as illegal. An optional second byte carries its own enable bit and, when that bit is set, a new mode: input type, rejection filter pair and speed.

Decoded values are first held in pending registers. They move to the active registers that steer the analog mux and the modulator only when the converter starts its next conversion. A field that no write touches keeps its value for as long as needed. The converter starts a conversion by itself straight after reset, using the default setup. Bytes are taken only between the end of one conversion and the start of the next.

Top module: `adc_cfg_decoder`

## Requirements
- R1: After reset the active selection is differential with channel code 000 and no polarity swap (channel 0 positive, channel 1 negative). The active mode bits are all 0 (input select 0, combined 50/60 Hz rejection, 1x speed with auto-calibration). `bad_prefix` is low.
- R2: Reset leaves the converter busy, as does a `conv_start` pulse; a `conv_done` pulse ends the busy period. While busy, every byte is ignored and the byte position does not advance.
- R3: Bits 7:5 of the first byte of a transaction are the prefix. Prefix 101 loads the pending selection: bit 4 is single-ended (1) or differential (0), bit 3 is the polarity swap, bits 2:0 are the channel code.
- R4: Prefix 000 or 100 leaves the pending selection unchanged and does not raise `bad_prefix`.
- R5: Any other prefix (001, 010, 011, 110, 111) leaves the pending selection unchanged and pulses `bad_prefix` high for exactly the one cycle after the byte.
- R6: The second byte of a transaction has its enable in bit 7. When that bit is 1, bits 6, 5, 4 and 3 load input select, filter bit A, filter bit B and speed. Bits 2:0 are ignored. The second byte is processed whatever prefix the first byte carried.
- R7: A second byte with bit 7 at 0 leaves the pending mode unchanged.
- R8: A third or later byte of one transaction changes nothing.
- R9: `txn_start` or `txn_stop` rewinds the byte position, so the next accepted byte is decoded as a first byte.
- R10: The active outputs change only on the clock edge where `conv_start` is high. They then take the pending values held before that edge and show them from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_data | input | 8 | Received data byte |
| byte_valid | input | 1 | One-cycle strobe, `byte_data` valid |
| txn_start | input | 1 | Start or repeated start seen on the bus |
| txn_stop | input | 1 | Stop seen on the bus |
| conv_start | input | 1 | Converter begins a conversion |
| conv_done | input | 1 | Converter finished a conversion |
| act_single | output | 1 | Active single-ended (1) or differential (0) |
| act_odd | output | 1 | Active polarity / odd-channel bit |
| act_chan | output | 3 | Active channel code |
| act_im | output | 1 | Active input-select mode bit |
| act_fa | output | 1 | Active rejection filter bit A |
| act_fb | output | 1 | Active rejection filter bit B |
| act_spd | output | 1 | Active speed bit (1 = 2x) |
| bad_prefix | output | 1 | One-cycle pulse after an illegal first-byte prefix |

## Verification
The assertions assume that `byte_valid` never shares a cycle with `txn_start`, `txn_stop` or `conv_start`, and that `conv_start` and `conv_done` never coincide. Under these conditions a first-byte decode cannot repeat on the next cycle, and pending state seen in a busy cycle must still be there one cycle later. The bench drives every control as a one-cycle pulse on the falling edge and never puts two of them in the same cycle. Each conversion is followed by a separate done pulse before any byte is sent.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int CHAN_W = 3;
    localparam int PFX_W  = 3;

    typedef struct packed {
        logic              single;
        logic              odd;
        logic [CHAN_W-1:0] chan;
    } chan_cfg_t;

    typedef struct packed {
        logic im;
        logic fa;
        logic fb;
        logic spd;
    } mode_cfg_t;

    localparam int CHAN_CFG_W = $bits(chan_cfg_t);
    localparam int MODE_CFG_W = $bits(mode_cfg_t);

    localparam chan_cfg_t CHAN_RST = '{single: 1'b0, odd: 1'b0, chan: '0};
    localparam mode_cfg_t MODE_RST = '{im: 1'b0, fa: 1'b0, fb: 1'b0, spd: 1'b0};

    localparam logic [PFX_W-1:0] PFX_HOLD_A = 3'b000;
    localparam logic [PFX_W-1:0] PFX_HOLD_B = 3'b100;
    localparam logic [PFX_W-1:0] PFX_LOAD   = 3'b101;

    typedef enum logic [1:0] {
        SLOT_FIRST  = 2'd0,
        SLOT_SECOND = 2'd1,
        SLOT_FULL   = 2'd2
    } slot_e;

endpackage

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq
    import adc_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_valid,
    input  logic txn_start,
    input  logic txn_stop,
    input  logic conv_start,
    input  logic conv_done,
    output logic take_first,
    output logic take_second,
    output logic busy,
    output logic frame_full
);

    typedef struct packed {
        slot_e slot;
        logic  busy;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       accept;

    assign accept = byte_valid && !st_q.busy;

    always_comb begin
        st_d = st_q;
        if (conv_start) begin
            st_d.busy = 1'b1;
        end else if (conv_done) begin
            st_d.busy = 1'b0;
        end
        if (txn_start || txn_stop) begin
            st_d.slot = SLOT_FIRST;
        end else if (accept) begin
            case (st_q.slot)
                SLOT_FIRST:  st_d.slot = SLOT_SECOND;
                SLOT_SECOND: st_d.slot = SLOT_FULL;
                default:     st_d.slot = SLOT_FULL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{slot: SLOT_FIRST, busy: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign take_first  = accept && (st_q.slot == SLOT_FIRST);
    assign take_second = accept && (st_q.slot == SLOT_SECOND);
    assign busy        = st_q.busy;
    assign frame_full  = st_q.slot == SLOT_FULL;

    AST_REWIND_NO_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start || txn_stop) |=> !take_second); // R9
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !(take_first || take_second)); // R2

endmodule

// File: rtl/adc_cfg_chan_dec.sv
module adc_cfg_chan_dec
    import adc_cfg_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              take_first,
    output chan_cfg_t         pend_chan,
    output logic              bad_prefix
);

    localparam int PFX_MSB = DATA_W - 1;

    typedef struct packed {
        chan_cfg_t chan;
        logic      bad;
    } chan_state_t;

    chan_state_t       st_d, st_q;
    logic [PFX_W-1:0]  prefix;
    chan_cfg_t         payload;

    assign prefix  = byte_data[PFX_MSB -: PFX_W];
    assign payload = chan_cfg_t'(byte_data[CHAN_CFG_W-1:0]);

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (take_first) begin
            case (prefix)
                PFX_LOAD:               st_d.chan = payload;
                PFX_HOLD_A, PFX_HOLD_B: st_d.chan = st_q.chan;
                default:                st_d.bad  = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{chan: CHAN_RST, bad: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_chan  = st_q.chan;
    assign bad_prefix = st_q.bad;

    AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_prefix |=> !bad_prefix); // R5
    AST_FLAG_KEEPS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        bad_prefix |-> $stable(pend_chan)); // R5
    AST_HOLD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        (take_first && (prefix != PFX_LOAD)) |=> $stable(pend_chan)); // R4

endmodule

// File: rtl/adc_cfg_mode_dec.sv
module adc_cfg_mode_dec
    import adc_cfg_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              take_second,
    output mode_cfg_t         pend_mode
);

    localparam int EN_BIT    = DATA_W - 1;
    localparam int FIELD_MSB = DATA_W - 2;
    localparam int SPARE_W   = DATA_W - 1 - MODE_CFG_W;

    mode_cfg_t         mode_d, mode_q;
    logic              enable;
    logic [SPARE_W-1:0] unused_spare;

    assign enable       = byte_data[EN_BIT];
    assign unused_spare = byte_data[SPARE_W-1:0];

    always_comb begin
        mode_d = mode_q;
        if (take_second && enable) begin
            mode_d = mode_cfg_t'(byte_data[FIELD_MSB -: MODE_CFG_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign pend_mode = mode_q;

    AST_EN2_LOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (take_second && !enable) |=> $stable(pend_mode)); // R7

endmodule

// File: rtl/adc_cfg_decoder.sv
module adc_cfg_decoder
    import adc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_valid,
    input  logic              txn_start,
    input  logic              txn_stop,
    input  logic              conv_start,
    input  logic              conv_done,
    output logic              act_single,
    output logic              act_odd,
    output logic [CHAN_W-1:0] act_chan,
    output logic              act_im,
    output logic              act_fa,
    output logic              act_fb,
    output logic              act_spd,
    output logic              bad_prefix
);

    typedef struct packed {
        chan_cfg_t chan;
        mode_cfg_t mode;
    } act_state_t;

    logic       take_first, take_second, busy, frame_full;
    chan_cfg_t  pend_chan;
    mode_cfg_t  pend_mode;
    act_state_t act_d, act_q;

    adc_cfg_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid  (byte_valid),
        .txn_start   (txn_start),
        .txn_stop    (txn_stop),
        .conv_start  (conv_start),
        .conv_done   (conv_done),
        .take_first  (take_first),
        .take_second (take_second),
        .busy        (busy),
        .frame_full  (frame_full)
    );

    adc_cfg_chan_dec #(.DATA_W(BYTE_W)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_data  (byte_data),
        .take_first (take_first),
        .pend_chan  (pend_chan),
        .bad_prefix (bad_prefix)
    );

    adc_cfg_mode_dec #(.DATA_W(BYTE_W)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_data   (byte_data),
        .take_second (take_second),
        .pend_mode   (pend_mode)
    );

    always_comb begin
        act_d = act_q;
        if (conv_start) begin
            act_d.chan = pend_chan;
            act_d.mode = pend_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '{chan: CHAN_RST, mode: MODE_RST};
        end else begin
            act_q <= act_d;
        end
    end

    assign act_single = act_q.chan.single;
    assign act_odd    = act_q.chan.odd;
    assign act_chan   = act_q.chan.chan;
    assign act_im     = act_q.mode.im;
    assign act_fa     = act_q.mode.fa;
    assign act_fb     = act_q.mode.fb;
    assign act_spd    = act_q.mode.spd;

    AST_ACTIVE_ON_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |=> $stable(act_q)); // R10
    AST_BUSY_FREEZES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(pend_chan) && $stable(pend_mode))); // R2
    AST_FULL_FRAME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_full && byte_valid) |=> ($stable(pend_chan) && $stable(pend_mode))); // R8

endmodule

// File: tb/adc_cfg_decoder_tb.sv
`timescale 1ns/1ps
module adc_cfg_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_valid = 1'b0;
    logic       txn_start = 1'b0;
    logic       txn_stop = 1'b0;
    logic       conv_start = 1'b0;
    logic       conv_done = 1'b0;
    logic       act_single, act_odd, act_im, act_fa, act_fb, act_spd, bad_prefix;
    logic [2:0] act_chan;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [8:0] cfg;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    // Reference model state: {single, odd, chan[2:0]} and {im, fa, fb, spd}
    logic [4:0] m_chan = 5'b00000;
    logic [3:0] m_mode = 4'b0000;
    logic [8:0] m_act  = 9'b0;
    bit         m_busy = 1'b1;
    int         m_slot = 0;

    always #2.5 clk = ~clk;

    adc_cfg_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .txn_start  (txn_start),
        .txn_stop   (txn_stop),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .act_single (act_single),
        .act_odd    (act_odd),
        .act_chan   (act_chan),
        .act_im     (act_im),
        .act_fa     (act_fa),
        .act_fb     (act_fb),
        .act_spd    (act_spd),
        .bad_prefix (bad_prefix)
    );

    function automatic logic [8:0] act_bus();
        return {act_single, act_odd, act_chan, act_im, act_fa, act_fb, act_spd};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Monitor: each conversion start pops one expected active setup
    initial begin
        forever begin
            @(posedge clk);
            if (conv_start) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected conversion", act_bus(), 9'b0);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    check(act_bus() === it.cfg, it.tag, act_bus(), it.cfg);
                end
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input string tag);
        bit exp_bad;
        exp_bad = 1'b0;
        if (!m_busy) begin
            if (m_slot == 0) begin
                if (b[7:5] == 3'b101) m_chan = b[4:0];
                else if (b[7:5] != 3'b000 && b[7:5] != 3'b100) exp_bad = 1'b1;
                m_slot = 1;
            end else if (m_slot == 1) begin
                if (b[7]) m_mode = b[6:3];
                m_slot = 2;
            end
        end
        byte_data  = b;
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data  = '0;
        check(bad_prefix === exp_bad, tag, {8'b0, bad_prefix}, {8'b0, exp_bad});
    endtask

    task automatic bus_start();
        txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
        m_slot = 0;
    endtask

    task automatic bus_stop();
        txn_stop = 1'b1;
        @(negedge clk);
        txn_stop = 1'b0;
        m_slot = 0;
    endtask

    task automatic finish_conv();
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        m_busy = 1'b0;
    endtask

    task automatic convert(input string tag, input bit with_done);
        exp_item_t it;
        m_act  = {m_chan, m_mode};
        it.cfg = m_act;
        it.tag = tag;
        exp_q.push_back(it);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        m_busy = 1'b1;
        if (with_done) finish_conv();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset defaults
        check(act_bus() === 9'b0, "R1 reset active setup", act_bus(), 9'b0);
        check(bad_prefix === 1'b0, "R1 reset flag", {8'b0, bad_prefix}, 9'b0);

        // R2: bytes during the power-up conversion are ignored
        bus_start();
        send_byte(8'hBF, "R2 byte while busy");
        send_byte(8'hF8, "R2 second byte while busy");
        bus_stop();
        finish_conv();
        convert("R2 busy writes ignored", 1'b1);

        // R3 + R10: load prefix, active unchanged until conversion start
        bus_start();
        send_byte(8'b101_1_0_011, "R3 load byte");
        bus_stop();
        repeat (3) @(negedge clk);
        check(act_bus() === m_act, "R10 active held before start", act_bus(), m_act);
        convert("R3 channel loaded", 1'b1);

        // R4: hold prefixes
        bus_start();
        send_byte(8'b000_0_1_110, "R4 prefix 000 no flag");
        bus_stop();
        convert("R4 prefix 000 keeps channel", 1'b1);
        bus_start();
        send_byte(8'b100_0_1_101, "R4 prefix 100 no flag");
        bus_stop();
        convert("R4 prefix 100 keeps channel", 1'b1);

        // R5: illegal prefixes
        foreach (exp_q[i]) begin end
        for (int p = 1; p < 8; p++) begin
            if (p == 4 || p == 5) continue;
            bus_start();
            send_byte({p[2:0], 5'b01010}, "R5 illegal prefix flag");
            bus_stop();
            convert("R5 illegal prefix keeps channel", 1'b1);
        end

        // R6: two bytes, enable set
        bus_start();
        send_byte(8'b101_0_1_001, "R6 first byte");
        send_byte(8'b1_1_0_1_1_000, "R6 second byte");
        bus_stop();
        convert("R6 mode loaded", 1'b1);

        // R7: two bytes, enable clear
        bus_start();
        send_byte(8'b101_0_0_010, "R7 first byte");
        send_byte(8'b0_0_1_0_0_111, "R7 second byte");
        bus_stop();
        convert("R7 mode kept", 1'b1);

        // R8: third byte ignored
        bus_start();
        send_byte(8'b100_0_0_000, "R8 first byte");
        send_byte(8'b1_0_1_0_0_000, "R8 second byte");
        send_byte(8'hFF, "R8 third byte no flag");
        bus_stop();
        convert("R8 third byte ignored", 1'b1);

        // R9: repeated start rewinds the byte position
        bus_start();
        send_byte(8'b000_0_0_000, "R9 first byte");
        bus_start();
        send_byte(8'b101_1_1_100, "R9 byte after restart");
        send_byte(8'b0_1_1_1_1_000, "R9 second byte after restart");
        bus_stop();
        convert("R9 restart decodes first byte", 1'b1);

        // R9: stop rewinds the byte position
        bus_start();
        send_byte(8'b000_0_0_000, "R9 stop first");
        send_byte(8'b0_0_0_0_0_000, "R9 stop second");
        bus_stop();
        send_byte(8'b101_1_0_001, "R9 byte after stop");
        bus_stop();
        convert("R9 stop decodes first byte", 1'b1);

        // R2: writes between start and done of a later conversion are ignored
        convert("R10 plain conversion", 1'b0);
        bus_start();
        send_byte(8'b101_0_1_111, "R2 mid-conversion byte");
        send_byte(8'b1_1_1_1_1_000, "R2 mid-conversion second byte");
        bus_stop();
        finish_conv();
        convert("R2 mid-conversion writes ignored", 1'b1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all conversions observed", 9'(exp_q.size()), 9'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule